// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing protocol engine of a byte-addressed serial memory that answers on a two-wire (I2C-style) bus. SCL and SDA are oversampled in the system clock domain. The engine drives SDA only through an open-drain output enable. It recognises start and stop conditions and accepts a device select byte that carries a fixed family code and three strap bits. It then takes a two-byte word address and either forwards the data bytes that follow to a write buffer port, or returns bytes that it fetches from a synchronous memory read port.

A single address pointer lives inside the block and survives from one transaction to the next. A read that names no address continues from where the last access stopped. A random read loads the pointer with a short write header, then issues a repeated start. While the write sequencer reports that it is busy, the engine refuses to acknowledge its select byte, so a host can poll until the write has finished. The array size and page size are parameters.

Top module: `tw_eeprom_slave`

## Requirements
- R1: While reset is asserted and directly after it, the SDA output enable is released and neither the read strobe nor the write strobe is active.
- R2: A start condition is SDA falling while SCL is high, and a stop condition is SDA rising while SCL is high. A start seen at any bit position abandons the transfer in progress and waits for a new select byte. A stop returns the engine to idle. Neither changes the pointer.
- R3: The select byte is sent MSB first. Bits 7..4 must be 1010, bits 3..1 must equal the strap input (bit 3 matches strap bit 2), and bit 0 is 1 for a read and 0 for a write. On a match the engine pulls SDA low for the ninth clock. On a mismatch it leaves SDA released and ignores the bus until the next start.
- R4: While busy_i is high, a matching select byte is not acknowledged and nothing is written.
- R5: After a write select, two word address bytes follow, high byte first, and each is acknowledged. Address bits at or above log2(MEM_BYTES) are ignored when the pointer is loaded.
- R6: Each received data byte appears on the write port for one cycle, together with the pointer value, before its acknowledge. The pointer then increments in its low log2(PAGE_BYTES) bits only, so it wraps inside its page.
- R7: A read select with no address phase returns the byte at the pointer. The pointer always holds the last accessed address plus one.
- R8: A random read, made of a write select, two address bytes, a repeated start and a read select, returns data from the newly loaded address.
- R9: Within a read, each master acknowledge brings the byte at the next address, and the address wraps from MEM_BYTES-1 to 0.
- R10: A master no-acknowledge after a data byte ends the output. SDA stays released until the next stop or start.
- R11: The SDA output enable is asserted only in an acknowledge slot or for a read data bit of 0, and it only becomes asserted while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, raw |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | High pulls SDA low (open drain) |
| chip_sel_i | input | 3 | Strap value compared with select bits 3..1 |
| busy_i | input | 1 | Internal write cycle in progress |
| rd_en_o | output | 1 | Read strobe for the memory port |
| rd_addr_o | output | ADDR_W | Read address (current pointer) |
| rd_data_i | input | 8 | Read data, valid one cycle after rd_en_o |
| wr_en_o | output | 1 | One-cycle strobe for a received data byte |
| wr_addr_o | output | ADDR_W | Address of the received byte |
| wr_data_o | output | 8 | Received data byte |

## Verification
The bench builds the block with its defaults: an 8192-byte array, 32-byte pages, a two-stage synchroniser and the strap set to 101. With 8192 bytes the pointer is 13 bits wide. This lets the bench load word addresses that carry junk in bits 15..13, and it reaches the top-of-array wrap from 0x1FFF to 0 inside a single sequential read. With 32-byte pages, a short write that starts at offset 0x1E crosses the page end and lands back at the page base.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_RLOAD,
        ST_HOLD
    } tw_state_e;

    typedef enum logic [1:0] {
        K_SEL,
        K_AHI,
        K_ALO,
        K_WDAT
    } tw_kind_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } tw_line_ev_t;

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync
    import tw_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output tw_line_ev_t ev_o
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d        = q;
        d.scl_sh = {q.scl_sh[STAGES-2:0], scl_i};
        d.sda_sh = {q.sda_sh[STAGES-2:0], sda_i};
        d.scl_p  = q.scl_sh[STAGES-1];
        d.sda_p  = q.sda_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    logic scl_now, sda_now;
    assign scl_now = q.scl_sh[STAGES-1];
    assign sda_now = q.sda_sh[STAGES-1];

    always_comb begin
        ev_o.scl   = scl_now;
        ev_o.sda   = sda_now;
        ev_o.rise  = scl_now & ~q.scl_p;
        ev_o.fall  = ~scl_now & q.scl_p;
        ev_o.start = scl_now & q.scl_p & q.sda_p & ~sda_now;
        ev_o.stop  = scl_now & q.scl_p & ~q.sda_p & sda_now;
    end

endmodule

// File: rtl/tw_addr_ptr.sv
module tw_addr_ptr #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              inc_seq_i,
    input  logic              inc_page_i,
    output logic [ADDR_W-1:0] ptr_o
);

    logic [ADDR_W-1:0] ptr_d, ptr_q;
    logic [PAGE_W-1:0] low_next;

    assign low_next = ptr_q[PAGE_W-1:0] + PAGE_W'(1);

    always_comb begin
        ptr_d = ptr_q;
        if (load_i) begin
            ptr_d = load_val_i;
        end else if (inc_seq_i) begin
            ptr_d = ptr_q + ADDR_W'(1);
        end else if (inc_page_i) begin
            ptr_d = {ptr_q[ADDR_W-1:PAGE_W], low_next};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/tw_slave_fsm.sv
module tw_slave_fsm
    import tw_pkg::*;
#(
    parameter int         ADDR_W   = 13,
    parameter logic [3:0] DEV_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tw_line_ev_t       ev_i,
    input  logic [2:0]        chip_sel_i,
    input  logic              busy_i,
    output logic              ptr_load_o,
    output logic [ADDR_W-1:0] ptr_load_val_o,
    output logic              ptr_inc_seq_o,
    output logic              ptr_inc_page_o,
    output logic              rd_en_o,
    input  logic [7:0]        rd_data_i,
    output logic              wr_en_o,
    output logic [7:0]        wr_data_o,
    output logic              sda_oe_o
);

    typedef struct packed {
        tw_state_e  st;
        tw_kind_e   kind;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic [7:0] hi;
        logic [7:0] rbuf;
        logic       rpend;
        logic       rmode;
        logic       oe;
    } fsm_t;

    fsm_t q, d;

    logic        sel_hit;
    logic [15:0] full_addr;

    assign sel_hit   = (q.sh[7:4] == DEV_CODE) && (q.sh[3:1] == chip_sel_i) && !busy_i;
    assign full_addr = {q.hi, q.sh};

    always_comb begin
        d              = q;
        ptr_load_o     = 1'b0;
        ptr_inc_seq_o  = 1'b0;
        ptr_inc_page_o = 1'b0;
        rd_en_o        = 1'b0;
        wr_en_o        = 1'b0;
        ptr_load_val_o = full_addr[ADDR_W-1:0];

        if (q.rpend) begin
            d.rbuf  = rd_data_i;
            d.rpend = 1'b0;
        end

        if (ev_i.start) begin
            d.st    = ST_RX;
            d.kind  = K_SEL;
            d.cnt   = '0;
            d.rmode = 1'b0;
            d.oe    = 1'b0;
        end else if (ev_i.stop) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (ev_i.rise) begin
                        d.sh  = {q.sh[6:0], ev_i.sda};
                        d.cnt = q.cnt + 4'd1;
                    end else if (ev_i.fall && q.cnt == 4'd8) begin
                        d.cnt = '0;
                        d.st  = ST_ACK;
                        d.oe  = 1'b1;
                        unique case (q.kind)
                            K_SEL: begin
                                if (sel_hit) begin
                                    d.rmode = q.sh[0];
                                    if (q.sh[0]) begin
                                        rd_en_o = 1'b1;
                                        d.rpend = 1'b1;
                                    end
                                end else begin
                                    d.st = ST_IDLE;
                                    d.oe = 1'b0;
                                end
                            end
                            K_AHI: d.hi = q.sh;
                            K_ALO: ptr_load_o = 1'b1;
                            K_WDAT: begin
                                wr_en_o        = 1'b1;
                                ptr_inc_page_o = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_ACK: begin
                    if (ev_i.fall) begin
                        d.cnt = '0;
                        if (q.rmode) begin
                            d.st          = ST_TX;
                            d.sh          = q.rbuf;
                            d.oe          = ~q.rbuf[7];
                            ptr_inc_seq_o = 1'b1;
                        end else begin
                            d.st = ST_RX;
                            d.oe = 1'b0;
                            unique case (q.kind)
                                K_SEL:   d.kind = K_AHI;
                                K_AHI:   d.kind = K_ALO;
                                default: d.kind = K_WDAT;
                            endcase
                        end
                    end
                end
                ST_TX: begin
                    if (ev_i.rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (ev_i.fall) begin
                        if (q.cnt == 4'd8) begin
                            d.st  = ST_MACK;
                            d.oe  = 1'b0;
                            d.cnt = '0;
                        end else begin
                            d.sh = {q.sh[6:0], 1'b0};
                            d.oe = ~q.sh[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (ev_i.rise) begin
                        if (!ev_i.sda) begin
                            d.st    = ST_RLOAD;
                            rd_en_o = 1'b1;
                            d.rpend = 1'b1;
                        end else begin
                            d.st = ST_HOLD;
                        end
                    end
                end
                ST_RLOAD: begin
                    if (ev_i.fall) begin
                        d.st          = ST_TX;
                        d.cnt         = '0;
                        d.sh          = q.rbuf;
                        d.oe          = ~q.rbuf[7];
                        ptr_inc_seq_o = 1'b1;
                    end
                end
                default: d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, kind: K_SEL, default: '0};
        end else begin
            q <= d;
        end
    end

    assign wr_data_o = q.sh;
    assign sda_oe_o  = q.oe;

endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
    import tw_pkg::*;
#(
    parameter int MEM_BYTES   = 8192,
    parameter int PAGE_BYTES  = 32,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = $clog2(MEM_BYTES),
    localparam int PAGE_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [2:0]        chip_sel_i,
    input  logic              busy_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o
);

    tw_line_ev_t       ev;
    logic              scl_s;
    logic              ptr_load, ptr_inc_seq, ptr_inc_page;
    logic [ADDR_W-1:0] ptr_load_val, ptr;

    assign scl_s = ev.scl;

    tw_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    tw_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) ptr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ptr_load),
        .load_val_i (ptr_load_val),
        .inc_seq_i  (ptr_inc_seq),
        .inc_page_i (ptr_inc_page),
        .ptr_o      (ptr)
    );

    tw_slave_fsm #(.ADDR_W(ADDR_W)) fsm_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .ev_i           (ev),
        .chip_sel_i     (chip_sel_i),
        .busy_i         (busy_i),
        .ptr_load_o     (ptr_load),
        .ptr_load_val_o (ptr_load_val),
        .ptr_inc_seq_o  (ptr_inc_seq),
        .ptr_inc_page_o (ptr_inc_page),
        .rd_en_o        (rd_en_o),
        .rd_data_i      (rd_data_i),
        .wr_en_o        (wr_en_o),
        .wr_data_o      (wr_data_o),
        .sda_oe_o       (sda_oe_o)
    );

    assign rd_addr_o = ptr;
    assign wr_addr_o = ptr;

endmodule

// File: rtl/tw_eeprom_slave_chk.sv
module tw_eeprom_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_oe_o,
    input logic wr_en_o,
    input logic rd_en_o
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe_o && !wr_en_o && !rd_en_o));

    // R11
    oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_s);

    // R6
    wr_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);

    // R6
    wr_before_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> !sda_oe_o);

    // R9
    rd_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |=> !rd_en_o);

    // R7
    rd_wr_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_o && wr_en_o));

endmodule

bind tw_eeprom_slave tw_eeprom_slave_chk chk_i (.*);

// File: tb/tw_eeprom_slave_tb_top.sv
module tw_eeprom_slave_tb_top;

    localparam int MEM  = 8192;
    localparam int AW   = 13;
    localparam int HP   = 10;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic busy  = 1'b0;
    logic sda_oe, rd_en, wr_en;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [7:0] wr_data;
    logic [7:0] rd_q = 8'h00;
    wire  sda_line = sda_m & ~sda_oe;

    tw_eeprom_slave dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe),
        .chip_sel_i (STRAP),
        .busy_i     (busy),
        .rd_en_o    (rd_en),
        .rd_addr_o  (rd_addr),
        .rd_data_i  (rd_q),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data)
    );

    function automatic logic [7:0] pat(input int a);
        int t;
        t = (a * 29) ^ (a >> 5) ^ 32'h3C;
        return t[7:0];
    endfunction

    always @(posedge clk) if (rd_en) rd_q <= pat(int'(rd_addr));

    int wr_n = 0;
    logic [AW-1:0] wr_a [64];
    logic [7:0]    wr_d [64];
    always @(posedge clk) begin
        if (rst_n && wr_en) begin
            if (wr_n < 64) begin
                wr_a[wr_n] <= wr_addr;
                wr_d[wr_n] <= wr_data;
            end
            wr_n <= wr_n + 1;
        end
    end

    int checks = 0;
    int errors = 0;
    int exp_ptr = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_c;
        sda_m = 1'b1; wt(5);
        scl_m = 1'b1; wt(HP);
        sda_m = 1'b0; wt(HP);
        scl_m = 1'b0; wt(2);
    endtask

    task automatic stop_c;
        sda_m = 1'b0; wt(5);
        scl_m = 1'b1; wt(HP);
        sda_m = 1'b1; wt(HP);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            wt(3); sda_m = b[i]; wt(HP - 3);
            scl_m = 1'b1; wt(HP);
            scl_m = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        wt(3); sda_m = 1'b1; wt(HP - 3);
        scl_m = 1'b1; wt(HP / 2);
        ack = !sda_line;
        wt(HP / 2);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] d);
        sda_m = 1'b1;
        d = 8'h00;
        for (int i = 0; i < 8; i++) begin
            wt(HP); scl_m = 1'b1; wt(HP / 2);
            d = {d[6:0], sda_line};
            wt(HP / 2); scl_m = 1'b0;
        end
        wt(3); sda_m = mack ? 1'b0 : 1'b1; wt(HP - 3);
        scl_m = 1'b1; wt(HP);
        scl_m = 1'b0; wt(3);
        sda_m = 1'b1;
    endtask

    task automatic set_addr(input logic [15:0] a, input string req);
        bit ack;
        start_c;
        send_byte({4'b1010, STRAP, 1'b0}, ack);
        chk(ack, "R3", "write select ack", int'(ack), 1);
        send_byte(a[15:8], ack);
        chk(ack, req, "address high ack", int'(ack), 1);
        send_byte(a[7:0], ack);
        chk(ack, req, "address low ack", int'(ack), 1);
        exp_ptr = int'(a) % MEM;
    endtask

    // reads n bytes from the current pointer, repeated start included
    task automatic read_cur(input int n, input string req);
        bit ack;
        logic [7:0] d;
        start_c;
        send_byte({4'b1010, STRAP, 1'b1}, ack);
        chk(ack, "R3", "read select ack", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            chk(d == pat(exp_ptr), req, "read data R11", int'(d), int'(pat(exp_ptr)));
            exp_ptr = (exp_ptr + 1) % MEM;
        end
        wt(5);
        chk(sda_oe == 1'b0, "R10", "released after master nack", int'(sda_oe), 0);
        stop_c;
    endtask

    task automatic write_seq(input logic [15:0] a, input int n, input logic [7:0] d0, input string req);
        bit ack;
        int base, addr;
        set_addr(a, "R5");
        base = wr_n;
        addr = int'(a) % MEM;
        for (int i = 0; i < n; i++) begin
            send_byte(d0 + 8'(i), ack);
            chk(ack, req, "data byte ack", int'(ack), 1);
        end
        wt(5);
        chk(sda_oe == 1'b0, "R11", "released after write ack", int'(sda_oe), 0);
        stop_c;
        chk(wr_n == base + n, req, "write strobe count", wr_n, base + n);
        for (int i = 0; i < n; i++) begin
            if (base + i < 64) begin
                chk(int'(wr_a[base + i]) == addr, req, "write address", int'(wr_a[base + i]), addr);
                chk(wr_d[base + i] == d0 + 8'(i), req, "write data", int'(wr_d[base + i]), int'(d0 + 8'(i)));
            end
            addr = (addr & ~31) | ((addr + 1) & 31);
        end
        exp_ptr = addr;
    endtask

    initial begin
        bit ack;
        int seed;
        seed = int'($urandom(32'd2024));
        wt(4);
        // R1 reset state
        chk(sda_oe == 1'b0 && wr_en == 1'b0 && rd_en == 1'b0, "R1", "outputs in reset",
            int'({sda_oe, wr_en, rd_en}), 0);
        rst_n = 1'b1;
        wt(5);
        chk(sda_oe == 1'b0, "R1", "oe after reset", int'(sda_oe), 0);

        // R6 plain write, then R7 current-address read
        write_seq(16'h0123, 3, 8'h40, "R6");
        read_cur(2, "R7");

        // R6 page wrap inside page 0x7E0
        write_seq(16'h07FE, 4, 8'hA0, "R6");
        chk(exp_ptr == 32'h7E2, "R6", "page wrap pointer model", exp_ptr, 32'h7E2);
        read_cur(1, "R7");

        // R8 random read, R9 wrap across top of array
        set_addr(16'h1FFE, "R5");
        read_cur(3, "R9");

        // R5 upper address bits ignored
        set_addr(16'hE005, "R5");
        read_cur(2, "R8");

        // R3 wrong strap and wrong family code
        start_c;
        send_byte({4'b1010, STRAP ^ 3'b001, 1'b1}, ack);
        chk(!ack, "R3", "wrong strap no ack", int'(ack), 0);
        stop_c;
        start_c;
        send_byte({4'b1011, STRAP, 1'b0}, ack);
        chk(!ack, "R3", "wrong family no ack", int'(ack), 0);
        send_byte(8'h12, ack);
        chk(!ack, "R3", "ignored until start", int'(ack), 0);
        stop_c;
        read_cur(1, "R3");

        // R4 busy polling
        busy = 1'b1;
        begin
            int base;
            base = wr_n;
            start_c;
            send_byte({4'b1010, STRAP, 1'b0}, ack);
            chk(!ack, "R4", "busy write select", int'(ack), 0);
            send_byte(8'h00, ack);
            send_byte(8'h10, ack);
            send_byte(8'h55, ack);
            stop_c;
            chk(wr_n == base, "R4", "no write while busy", wr_n, base);
            start_c;
            send_byte({4'b1010, STRAP, 1'b1}, ack);
            chk(!ack, "R4", "busy read select", int'(ack), 0);
            stop_c;
        end
        busy = 1'b0;
        read_cur(1, "R4");

        // R2 start in the middle of an address byte aborts it
        start_c;
        send_byte({4'b1010, STRAP, 1'b0}, ack);
        send_bits(8'hC3, 4);
        read_cur(2, "R2");
        start_c;
        send_bits(8'hA5, 5);
        stop_c;
        chk(sda_oe == 1'b0, "R2", "idle after stop", int'(sda_oe), 0);
        read_cur(1, "R2");

        // constrained random reads and writes
        for (int k = 0; k < 16; k++) begin
            logic [15:0] a;
            a = 16'($urandom());
            set_addr(a, "R5");
            read_cur(1 + int'($urandom() % 4), "R8");
        end
        for (int k = 0; k < 4; k++) begin
            write_seq(16'($urandom()), 1 + int'($urandom() % 5), 8'($urandom()), "R6");
            read_cur(1, "R7");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule